// File: doc/BRIEF.md
# Packed Masked Signed 64-bit to Single-Precision Converter

This block turns a vector of signed 64-bit integers into packed IEEE-754 single-precision values. A single shared converter handles the lanes one per clock. Each result is 32 bits wide, so the packed result covers half the width of the source vector. A pulse on `start_i` samples every operand. `done_o` rises once the last lane has been written. The destination and the flags then hold until the next accepted start.

Several controls surround each conversion. A per-lane write mask selects which lanes convert. An inactive lane either keeps its previous destination value (merge) or is written with zero. A broadcast flag makes every lane convert element 0. All destination lanes above the active vector length are cleared. A reserved 4-bit operand field must read all ones; any other value flags a bad encoding and leaves the destination untouched. Rounding follows a selectable mode, and the widest vector length accepts an explicit override of that mode. An inexact flag collects the lost precision across the lanes that actually converted.

Top module: `i2f_pack_cvt`

## Requirements
- R1: `vsel_i` sets the lane count: 0 gives 2 lanes, 1 gives 4 lanes, 2 or 3 gives 8 lanes. For a valid encoding, `done_o` is first high after the KL-th clock edge following the edge that accepts `start_i`, and `busy_o` and `done_o` are never high together.
- R2: Lane j converts source bits [64j+63:64j], read as two's complement, into destination bits [32j+31:32j]. Zero gives +0.0. A negative value is converted by its magnitude with bit 31 set.
- R3: `rmode_i` encodes the rounding: 0 is nearest-even, 1 is toward minus infinity, 2 is toward plus infinity, 3 is toward zero. Rounding acts on the bits below the 24-bit significand, and a carry out of rounding raises the exponent by one.
- R4: When `vsel_i` selects 8 lanes and `rnd_ovr_en_i` is 1, `rnd_ovr_i` (same encoding as R3) replaces `rmode_i`. With 2 or 4 lanes the override is ignored.
- R5: With `mask_en_i` = 0 every lane converts. With `mask_en_i` = 1, lane j converts only when `mask_i[j]` is 1.
- R6: An inactive lane keeps its `old_dst_i` lane value when `zero_mode_i` = 0 and becomes zero when `zero_mode_i` = 1.
- R7: With `bcast_i` = 1, every lane converts source bits [63:0].
- R8: Every destination lane j with j >= KL reads zero after completion.
- R9: If `rsvd_i` is not 4'hF, then `bad_enc_o` = 1, `dst_o` equals `old_dst_i` in full, `inexact_o` = 0, and `done_o` is high after the accepting edge itself. The next valid operation clears `bad_enc_o`.
- R10: `inexact_o` is the OR, over the lanes that convert, of nonzero bits discarded by rounding. Inactive lanes do not contribute.
- R11: From `done_o` until the next accepted start, `dst_o`, `inexact_o` and `bad_enc_o` hold, whatever the other inputs do.
- R12: After reset, `dst_o` is zero and `inexact_o`, `bad_enc_o`, `busy_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (ignored while busy) |
| vsel_i | input | 2 | Vector length select |
| src_i | input | 512 | Packed signed 64-bit source elements |
| mask_en_i | input | 1 | Enable per-lane masking |
| mask_i | input | 8 | Per-lane write mask |
| zero_mode_i | input | 1 | 1: zero inactive lanes, 0: merge |
| bcast_i | input | 1 | Convert element 0 in every lane |
| rmode_i | input | 2 | Default rounding mode |
| rnd_ovr_en_i | input | 1 | Enable rounding override (8 lanes only) |
| rnd_ovr_i | input | 2 | Override rounding mode |
| rsvd_i | input | 4 | Reserved field, must be 4'hF |
| old_dst_i | input | 256 | Previous destination contents |
| dst_o | output | 256 | Packed single-precision result |
| inexact_o | output | 1 | Precision lost in an active lane |
| bad_enc_o | output | 1 | Reserved field violation |
| busy_o | output | 1 | Lanes being processed |
| done_o | output | 1 | Result valid and held |

## Verification
The hardest case to reach from the ports is a rounding carry that spills into the exponent. Only a source whose top 24 significant bits are all ones, together with nonzero discarded bits and a rounding direction that increments, produces it. The stimulus uses the largest positive 64-bit value under nearest-even and again under toward-zero, so both sides of that carry are compared. A second hard case is an inexact lane hidden behind a clear mask bit. The bench places a value that cannot be represented exactly in one lane and repeats the same operation with that lane masked off and then enabled.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_DOWN = 2'd1,
    RM_UP   = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  // 0: 2 lanes, 1: 4 lanes, 2/3: 8 lanes
  function automatic logic [3:0] lanes_of(input logic [1:0] vsel);
    case (vsel)
      2'd0:    lanes_of = 4'd2;
      2'd1:    lanes_of = 4'd4;
      default: lanes_of = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/i2f_lead_one.sv
module i2f_lead_one #(
  parameter int W  = 64,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o,
  output logic          any_o
);
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) pos_o = PW'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/i2f_lane_cvt.sv
module i2f_lane_cvt
  import i2f_pkg::*;
#(
  parameter int IN_W = 64
) (
  input  logic [IN_W-1:0] int_i,
  input  rmode_e          rm_i,
  output logic [31:0]     fp_o,
  output logic            inexact_o
);
  localparam int PW       = $clog2(IN_W);
  localparam int MAN_W    = 24;
  localparam int LO_W     = IN_W - MAN_W;
  localparam int EXP_BIAS = 127;

  logic            neg;
  logic [IN_W-1:0] mag, norm;
  logic [PW-1:0]   pos;
  logic            any;
  logic [MAN_W-1:0] keep;
  logic            grd, stk, inc;
  logic [MAN_W:0]  sum;
  logic [7:0]      exp_f;

  assign neg = int_i[IN_W-1];
  assign mag = neg ? (~int_i + 1'b1) : int_i;

  i2f_lead_one #(.W(IN_W)) u_lead (
    .vec_i(mag),
    .pos_o(pos),
    .any_o(any)
  );

  always_comb begin
    norm = mag << (PW'(IN_W - 1) - pos);
    keep = norm[IN_W-1 -: MAN_W];
    grd  = norm[LO_W-1];
    stk  = |norm[LO_W-2:0];
    case (rm_i)
      RM_NEAR: inc = grd & (stk | keep[0]);
      RM_DOWN: inc = neg & (grd | stk);
      RM_UP:   inc = ~neg & (grd | stk);
      default: inc = 1'b0;
    endcase
    sum   = {1'b0, keep} + (MAN_W+1)'(inc);
    // carry out leaves sum[22:0] zero, only exponent moves
    exp_f = 8'(EXP_BIAS) + 8'(pos) + 8'(sum[MAN_W]);
    fp_o      = any ? {neg, exp_f, sum[22:0]} : 32'd0;
    inexact_o = any & (grd | stk);
  end

  always_comb begin
    // R2
    if (int_i == '0) zero_map_chk: assert (fp_o == 32'd0 && !inexact_o);
    // R2
    if (int_i != '0) sign_keep_chk: assert (fp_o[31] == int_i[IN_W-1]);
  end
endmodule

// File: rtl/i2f_lane_seq.sv
module i2f_lane_seq
  import i2f_pkg::*;
#(
  parameter int LANES_MAX = 8,
  localparam int IDX_W = $clog2(LANES_MAX),
  localparam int KL_W  = $clog2(LANES_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             reject_i,
  input  logic [1:0]       vsel_i,
  output logic             accept_o,
  output logic             fire_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [KL_W-1:0]  kl_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q, done_q, last;
  logic [IDX_W-1:0] idx_q;
  logic [KL_W-1:0]  kl_q;

  assign accept_o = start_i & ~busy_q;
  assign fire_o   = busy_q;
  assign idx_o    = idx_q;
  assign kl_o     = kl_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign last     = (KL_W'(idx_q) == kl_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      kl_q   <= KL_W'(2);
    end else if (accept_o) begin
      idx_q <= '0;
      kl_q  <= KL_W'(lanes_of(vsel_i));
      if (reject_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R1
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R1
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (KL_W'(idx_o) < kl_o));
  // R11
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/i2f_pack_cvt.sv
module i2f_pack_cvt
  import i2f_pkg::*;
#(
  parameter int LANES_MAX = 8,
  parameter int ELEM_W    = 64,
  parameter int RES_W     = 32,
  parameter int RSVD_W    = 4,
  localparam int SRC_W = LANES_MAX * ELEM_W,
  localparam int DST_W = LANES_MAX * RES_W,
  localparam int IDX_W = $clog2(LANES_MAX),
  localparam int KL_W  = $clog2(LANES_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        vsel_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              mask_en_i,
  input  logic [LANES_MAX-1:0] mask_i,
  input  logic              zero_mode_i,
  input  logic              bcast_i,
  input  logic [1:0]        rmode_i,
  input  logic              rnd_ovr_en_i,
  input  logic [1:0]        rnd_ovr_i,
  input  logic [RSVD_W-1:0] rsvd_i,
  input  logic [DST_W-1:0]  old_dst_i,
  output logic [DST_W-1:0]  dst_o,
  output logic              inexact_o,
  output logic              bad_enc_o,
  output logic              busy_o,
  output logic              done_o
);
  logic             accept, fire, reject;
  logic [IDX_W-1:0] idx;
  logic [KL_W-1:0]  kl, kl_new;

  logic [SRC_W-1:0]     src_q;
  logic [LANES_MAX-1:0] mask_q;
  logic                 zero_q, bcast_q, inx_q, bad_q;
  rmode_e               rm_q, rm_sel;
  logic [ELEM_W-1:0]    elem;
  logic [RES_W-1:0]     res;
  logic                 res_inx, lane_act;
  logic [RES_W-1:0]     lane_q [LANES_MAX];

  assign reject = (rsvd_i != {RSVD_W{1'b1}});
  assign kl_new = KL_W'(lanes_of(vsel_i));
  assign rm_sel = (rnd_ovr_en_i && kl_new == KL_W'(LANES_MAX)) ? rmode_e'(rnd_ovr_i)
                                                                : rmode_e'(rmode_i);

  i2f_lane_seq #(.LANES_MAX(LANES_MAX)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .reject_i(reject),
    .vsel_i  (vsel_i),
    .accept_o(accept),
    .fire_o  (fire),
    .idx_o   (idx),
    .kl_o    (kl),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      mask_q  <= '0;
      zero_q  <= 1'b0;
      bcast_q <= 1'b0;
      rm_q    <= RM_NEAR;
      inx_q   <= 1'b0;
      bad_q   <= 1'b0;
    end else if (accept) begin
      src_q   <= src_i;
      mask_q  <= mask_en_i ? mask_i : '1;
      zero_q  <= zero_mode_i;
      bcast_q <= bcast_i;
      rm_q    <= rm_sel;
      inx_q   <= 1'b0;
      bad_q   <= reject;
    end else if (fire && lane_act) begin
      inx_q <= inx_q | res_inx;
    end
  end

  assign elem     = bcast_q ? src_q[ELEM_W-1:0] : src_q[int'(idx)*ELEM_W +: ELEM_W];
  assign lane_act = mask_q[idx];

  i2f_lane_cvt #(.IN_W(ELEM_W)) u_cvt (
    .int_i    (elem),
    .rm_i     (rm_q),
    .fp_o     (res),
    .inexact_o(res_inx)
  );

  for (genvar j = 0; j < LANES_MAX; j++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q[j] <= '0;
      end else if (accept) begin
        // reject keeps everything; otherwise clear lanes beyond the vector
        if (reject || KL_W'(j) < kl_new) lane_q[j] <= old_dst_i[j*RES_W +: RES_W];
        else                             lane_q[j] <= '0;
      end else if (fire && idx == IDX_W'(j)) begin
        if (lane_act)    lane_q[j] <= res;
        else if (zero_q) lane_q[j] <= '0;
      end
    end
    assign dst_o[j*RES_W +: RES_W] = lane_q[j];

    // R8
    upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !bad_enc_o && KL_W'(j) >= kl) |-> (lane_q[j] == '0));
    // R6
    zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && idx == IDX_W'(j) && !lane_act && zero_q) |=> (lane_q[j] == '0));
    // R6
    merge_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && idx == IDX_W'(j) && !lane_act && !zero_q) |=> $stable(lane_q[j]));
  end

  assign inexact_o = inx_q;
  assign bad_enc_o = bad_q;

  // R9
  bad_no_inexact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_enc_o |-> !inexact_o);
  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> ($stable(dst_o) && $stable(inexact_o) && $stable(bad_enc_o)));
endmodule

// File: tb/sim_i2f_pack_cvt.sv
`timescale 1ns/1ps
module sim_i2f_pack_cvt;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   vsel_i = '0;
  logic [511:0] src_i = '0;
  logic         mask_en_i = 1'b0;
  logic [7:0]   mask_i = '0;
  logic         zero_mode_i = 1'b0;
  logic         bcast_i = 1'b0;
  logic [1:0]   rmode_i = '0;
  logic         rnd_ovr_en_i = 1'b0;
  logic [1:0]   rnd_ovr_i = '0;
  logic [3:0]   rsvd_i = 4'hF;
  logic [255:0] old_dst_i = '0;
  logic [255:0] dst_o;
  logic         inexact_o, bad_enc_o, busy_o, done_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  i2f_pack_cvt u0 (.*);

  // {source, rounding mode, expected float, expected inexact}
  localparam int NV = 14;
  localparam logic [98:0] VEC [NV] = '{
    {64'h0000_0000_0000_0001, 2'd0, 32'h3F80_0000, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 32'hBF80_0000, 1'b0},
    {64'h0000_0000_0000_0000, 2'd0, 32'h0000_0000, 1'b0},
    {64'h0000_0000_0000_0064, 2'd0, 32'h42C8_0000, 1'b0},
    {64'h0000_0000_0100_0001, 2'd0, 32'h4B80_0000, 1'b1},
    {64'h0000_0000_0100_0001, 2'd2, 32'h4B80_0001, 1'b1},
    {64'h0000_0000_0100_0001, 2'd1, 32'h4B80_0000, 1'b1},
    {64'hFFFF_FFFF_FEFF_FFFF, 2'd1, 32'hCB80_0001, 1'b1},
    {64'hFFFF_FFFF_FEFF_FFFF, 2'd2, 32'hCB80_0000, 1'b1},
    {64'h0000_0000_0100_0003, 2'd0, 32'h4B80_0002, 1'b1},
    {64'h7FFF_FFFF_FFFF_FFFF, 2'd0, 32'h5F00_0000, 1'b1},
    {64'h7FFF_FFFF_FFFF_FFFF, 2'd3, 32'h5EFF_FFFF, 1'b1},
    {64'h8000_0000_0000_0000, 2'd0, 32'hDF00_0000, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFE, 2'd3, 32'hC000_0000, 1'b0}
  };

  // floats of 1.0 .. 8.0
  localparam logic [31:0] SMALL [8] = '{
    32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, 32'h4080_0000,
    32'h40A0_0000, 32'h40C0_0000, 32'h40E0_0000, 32'h4100_0000
  };

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // pulse start, count negedges until done_o
  task automatic run_op(output int lat);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [255:0] exp_d, hold;

    repeat (2) @(negedge clk_i);
    // R12 reset state
    chk("R12", dst_o, '0);
    chk("R12", {251'd0, inexact_o, bad_enc_o, busy_o, done_o}, '0);
    rst_ni = 1'b1;

    // R2 R3 vector table, 2 lanes, upper destination preloaded with ones
    for (int v = 0; v < NV; v++) begin
      vsel_i = 2'd0;
      src_i = '0;
      src_i[63:0] = VEC[v][98:35];
      src_i[127:64] = VEC[v][98:35];
      rmode_i = VEC[v][34:33];
      old_dst_i = '1;
      run_op(lat);
      chk("R1", 256'(lat), 256'd3);
      chk("R2/R3 lane0", 256'(dst_o[31:0]), 256'(VEC[v][32:1]));
      chk("R2/R3 lane1", 256'(dst_o[63:32]), 256'(VEC[v][32:1]));
      chk("R8", dst_o[255:64], '0);
      chk("R10", 256'(inexact_o), 256'(VEC[v][0]));
    end
    rmode_i = 2'd0;

    // R5 R6 merge masking, 8 lanes
    vsel_i = 2'd2;
    for (int j = 0; j < 8; j++) begin
      src_i[j*64 +: 64] = 64'(j + 1);
      old_dst_i[j*32 +: 32] = 32'hAAAA_0000 + 32'(j);
    end
    mask_en_i = 1'b1;
    mask_i = 8'b1010_0101;
    zero_mode_i = 1'b0;
    run_op(lat);
    chk("R1", 256'(lat), 256'd9);
    for (int j = 0; j < 8; j++)
      exp_d[j*32 +: 32] = mask_i[j] ? SMALL[j] : (32'hAAAA_0000 + 32'(j));
    chk("R6 merge", dst_o, exp_d);

    // R6 zeroing
    zero_mode_i = 1'b1;
    run_op(lat);
    for (int j = 0; j < 8; j++)
      exp_d[j*32 +: 32] = mask_i[j] ? SMALL[j] : 32'd0;
    chk("R6 zero", dst_o, exp_d);

    // R5 mask disabled converts all lanes despite clear mask
    mask_en_i = 1'b0;
    mask_i = 8'h00;
    vsel_i = 2'd3;
    run_op(lat);
    chk("R1 code3", 256'(lat), 256'd9);
    for (int j = 0; j < 8; j++) exp_d[j*32 +: 32] = SMALL[j];
    chk("R5", dst_o, exp_d);

    // R7 broadcast over 4 lanes, R8 upper lanes cleared
    vsel_i = 2'd1;
    bcast_i = 1'b1;
    src_i[63:0] = 64'd100;
    old_dst_i = '1;
    run_op(lat);
    chk("R1", 256'(lat), 256'd5);
    chk("R7", 256'(dst_o[127:0]), 256'({4{32'h42C8_0000}}));
    chk("R8", dst_o[255:128], '0);
    bcast_i = 1'b0;

    // R10 inexact only from active lanes
    vsel_i = 2'd0;
    src_i[63:0] = 64'h0100_0001;
    src_i[127:64] = 64'd1;
    mask_en_i = 1'b1;
    mask_i = 8'b0000_0010;
    run_op(lat);
    chk("R10 masked", 256'(inexact_o), 256'd0);
    mask_i = 8'b0000_0001;
    run_op(lat);
    chk("R10 active", 256'(inexact_o), 256'd1);
    mask_en_i = 1'b0;

    // R4 override honoured at 8 lanes, ignored at 4
    for (int j = 0; j < 8; j++) src_i[j*64 +: 64] = 64'h0100_0001;
    rnd_ovr_en_i = 1'b1;
    rnd_ovr_i = 2'd2;
    vsel_i = 2'd2;
    run_op(lat);
    chk("R4 used", dst_o, {8{32'h4B80_0001}});
    vsel_i = 2'd1;
    run_op(lat);
    chk("R4 ignored", 256'(dst_o[127:0]), 256'({4{32'h4B80_0000}}));
    rnd_ovr_en_i = 1'b0;

    // R9 bad reserved field
    rsvd_i = 4'h7;
    old_dst_i = {8{32'h1234_5678}};
    run_op(lat);
    chk("R9 latency", 256'(lat), 256'd1);
    chk("R9 dst", dst_o, {8{32'h1234_5678}});
    chk("R9 flags", 256'({bad_enc_o, inexact_o}), 256'(2'b10));
    rsvd_i = 4'hF;
    vsel_i = 2'd0;
    run_op(lat);
    chk("R9 clear", 256'(bad_enc_o), 256'd0);

    // R11 outputs hold while inputs move without start
    hold = dst_o;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      src_i = ~src_i;
      old_dst_i = ~old_dst_i;
      rsvd_i = 4'(k);
      mask_i = 8'(k);
    end
    chk("R11 dst", dst_o, hold);
    chk("R11 flags", 256'({done_o, bad_enc_o, inexact_o}), 256'(3'b101));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule